// File: doc/BRIEF.md
# Serial Clock Glitch Monitor

This block watches the receive and transmit serial clock inputs of a serial controller. Both inputs come from outside the chip and are asynchronous to the system clock. Each input is brought into the system clock domain by its own synchronizer. The block then measures every high phase and every low phase in system clock cycles. A phase that lasts less than the minimum length (two cycles by default) is a glitch.

Each line that glitches sets its own sticky event bit, and the bit stays set until software writes a 1 to it. An interrupt output is raised while any event bit is set and that bit's mask bit is also set. A single enable input switches detection on or off. Detection should be off when an on-chip baud-rate generator drives the serial clock. It should also be off when the external clock is faster than one quarter of the system clock, because shorter valid phases would then be reported as glitches.

Top module: `clk_glitch_monitor`

## Requirements
- R1: After reset, `evt_o` is 0 and `irq_o` is 0.
- R2: A high phase of one system cycle on `rx_clk_i` sets `evt_o[0]` by the third rising system clock edge after the line returns low.
- R3: A low phase of one system cycle on a line that idles high is detected in the same way as a short high phase.
- R4: A clock whose high and low phases each last at least two system cycles raises no event. This covers a clock at one quarter of the system rate.
- R5: The transmit line is judged on its own. A glitch on `tx_clk_i` sets only `evt_o[1]`, and a glitch on `rx_clk_i` sets only `evt_o[0]`.
- R6: While `det_en_i` is 0, no event bit is ever set, whatever the clock lines do.
- R7: Turning `det_en_i` off leaves event bits that are already set unchanged.
- R8: Event bits are sticky. A bit is cleared only in a cycle where `clr_we_i` is 1 and the matching `clr_data_i` bit is 1. A 0 in `clr_data_i`, or any value while `clr_we_i` is 0, leaves the bit unchanged.
- R9: When a glitch is detected in the same cycle that its bit is being cleared, the bit ends up set.
- R10: `irq_o` is 1 exactly when some `evt_o[i]` and `evt_mask_i[i]` are both 1. A mask bit of 1 enables that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rx_clk_i | input | 1 | External receive serial clock, asynchronous |
| tx_clk_i | input | 1 | External transmit serial clock, asynchronous |
| det_en_i | input | 1 | Glitch detection enable |
| evt_mask_i | input | 2 | Interrupt enable per event (bit 0 = receive, bit 1 = transmit) |
| clr_we_i | input | 1 | Clear strobe for the event register |
| clr_data_i | input | 2 | Write-one-to-clear pattern for the event bits |
| evt_o | output | 2 | Sticky glitch events (bit 0 = receive, bit 1 = transmit) |
| irq_o | output | 1 | Masked OR of the event bits |

## Verification
A phase counter that is off by one shows up on the ports in one of two ways: a pulse of exactly two cycles is flagged, or a one-cycle pulse is missed. Either result is visible three cycles after the pulse ends. The tests therefore use both pulse widths and a clock running at one quarter of the system rate.

The bench checks the line-to-bit mapping and the clear and mask logic directly on `evt_o` and `irq_o`, one cycle after the write. It also drives a clear in the exact cycle an event lands, which shows whether set or clear wins.

If the enable gating is wrong, events appear while detection is off, or latched events are lost when detection is switched off. Both faults are checked within a few cycles of the stimulus.

// File: rtl/glitch_mon_pkg.sv
// Package: shared constants for the serial clock glitch monitor.
// Assumes line 0 is the receive clock and line 1 is the transmit clock.
package glitch_mon_pkg;
    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_RX   = 0;
    localparam int unsigned LINE_TX   = 1;
endpackage

// File: rtl/glitch_sync.sv
// Module: multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2. The output lags the input by STAGES system clocks.
module glitch_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Purpose: shift the asynchronous input through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/glitch_phase_chk.sv
// Module: measures the phases of one synchronized clock line and flags any
// phase shorter than MIN_PHASE cycles.
// Assumes line_i is already synchronized. The first edge after reset or after
// enable is not judged, because the length of the phase before it is unknown.
module glitch_phase_chk #(
    parameter int unsigned MIN_PHASE = 2,
    parameter int unsigned CNT_W     = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic line_i,
    output logic glitch_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_PHASE);

    logic             prev_q;
    logic             armed_q;
    logic [CNT_W-1:0] len_q;
    logic             edge_w;

    assign edge_w   = line_i ^ prev_q;
    assign glitch_o = en_i && edge_w && armed_q && (len_q < LIMIT);

    // Purpose: remember the previous level so that edges can be detected.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= line_i;
        end
    end

    // Purpose: count the cycles since the last edge, saturating at the limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            len_q   <= '0;
            armed_q <= 1'b0;
        end else if (edge_w) begin
            len_q   <= CNT_W'(1);
            armed_q <= 1'b1;
        end else if (len_q < LIMIT) begin
            len_q   <= len_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/glitch_evt_reg.sv
// Module: sticky event bits with write-one-to-clear, and the masked interrupt.
// Assumes set_i is a single-cycle detect pulse. A set wins over a clear in
// the same cycle.
module glitch_evt_reg #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_data_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] evt_o,
    output logic         irq_o
);
    logic [N-1:0] evt_q;
    logic [N-1:0] clr_w;

    assign clr_w = clr_we_i ? clr_data_i : '0;

    // Purpose: latch detect pulses and apply software clears.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            evt_q <= '0;
        end else begin
            evt_q <= (evt_q & ~clr_w) | set_i;
        end
    end

    assign evt_o = evt_q;
    assign irq_o = |(evt_q & mask_i);
endmodule

// File: rtl/clk_glitch_monitor.sv
// Module: top level of the serial clock glitch monitor.
// Assumes the external clocks run at no more than a quarter of clk_i, so that
// every valid phase lasts at least MIN_PHASE system cycles.
module clk_glitch_monitor
    import glitch_mon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_PHASE   = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rx_clk_i,
    input  logic                 tx_clk_i,
    input  logic                 det_en_i,
    input  logic [NUM_LINES-1:0] evt_mask_i,
    input  logic                 clr_we_i,
    input  logic [NUM_LINES-1:0] clr_data_i,
    output logic [NUM_LINES-1:0] evt_o,
    output logic                 irq_o
);
    localparam int unsigned CNT_W = $clog2(MIN_PHASE + 1);

    logic [NUM_LINES-1:0] raw_w;
    logic [NUM_LINES-1:0] sync_w;
    logic [NUM_LINES-1:0] glitch_w;

    assign raw_w[LINE_RX] = rx_clk_i;
    assign raw_w[LINE_TX] = tx_clk_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        glitch_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (raw_w[g]),
            .sync_o  (sync_w[g])
        );

        glitch_phase_chk #(
            .MIN_PHASE (MIN_PHASE),
            .CNT_W     (CNT_W)
        ) u_phase (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (det_en_i),
            .line_i   (sync_w[g]),
            .glitch_o (glitch_w[g])
        );
    end

    glitch_evt_reg #(
        .N (NUM_LINES)
    ) u_evt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (glitch_w),
        .clr_we_i   (clr_we_i),
        .clr_data_i (clr_data_i),
        .mask_i     (evt_mask_i),
        .evt_o      (evt_o),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/glitch_mon_chk.sv
// Module: assertion checker bound to clk_glitch_monitor.
// Assumes glitch_i is the detect vector between the phase checkers and the
// event register.
module glitch_mon_chk #(
    parameter int unsigned N = 2
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         det_en_i,
    input logic [N-1:0] evt_mask_i,
    input logic         clr_we_i,
    input logic [N-1:0] clr_data_i,
    input logic [N-1:0] evt_o,
    input logic         irq_o,
    input logic [N-1:0] glitch_i
);
    // R6
    en_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !det_en_i |=> ((evt_o & ~$past(evt_o)) == '0));

    // R6
    detect_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glitch_i != '0) |-> det_en_i);

    // R8
    evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_we_i |=> (($past(evt_o) & ~evt_o) == '0));

    // R8
    evt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_we_i |=> ((evt_o & $past(clr_data_i) & ~$past(glitch_i)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glitch_i != '0) |=> (($past(glitch_i) & ~evt_o) == '0));

    // R10
    irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_o & evt_mask_i) != '0) |-> irq_o);

    // R10
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_o & evt_mask_i) == '0) |-> !irq_o);
endmodule

bind clk_glitch_monitor glitch_mon_chk #(
    .N (glitch_mon_pkg::NUM_LINES)
) u_glitch_mon_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_en_i   (det_en_i),
    .evt_mask_i (evt_mask_i),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .evt_o      (evt_o),
    .irq_o      (irq_o),
    .glitch_i   (glitch_w)
);

// File: tb/test_clk_glitch_monitor.sv
// Bench: directed tests for clk_glitch_monitor, one task per scenario.
// Inputs are driven and outputs sampled on the falling clock edge.
module test_clk_glitch_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_clk = 1'b0;
    logic       tx_clk = 1'b0;
    logic       det_en = 1'b0;
    logic [1:0] mask = 2'b00;
    logic       clr_we = 1'b0;
    logic [1:0] clr_data = 2'b00;
    logic [1:0] evt;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clk_glitch_monitor i_clk_glitch_monitor (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .rx_clk_i   (rx_clk),
        .tx_clk_i   (tx_clk),
        .det_en_i   (det_en),
        .evt_mask_i (mask),
        .clr_we_i   (clr_we),
        .clr_data_i (clr_data),
        .evt_o      (evt),
        .irq_o      (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_clear(input logic [1:0] d);
        clr_we = 1'b1; clr_data = d;
        cyc(1);
        clr_we = 1'b0; clr_data = 2'b00;
    endtask

    // Drive a pulse on one line: line=0 rx, 1 tx; level is the pulse value.
    task automatic pulse(input int line, input logic level, input int width);
        if (line == 0) rx_clk = level; else tx_clk = level;
        cyc(width);
        if (line == 0) rx_clk = ~level; else tx_clk = ~level;
    endtask

    task automatic t_reset;
        check("R1 evt after reset", int'(evt), 0);
        check("R1 irq after reset", int'(irq), 0);
    endtask

    task automatic t_rx_high;
        det_en = 1'b1; mask = 2'b00;
        cyc(6);
        pulse(0, 1'b1, 1);
        cyc(4);
        check("R2 rx high glitch", int'(evt), 1);
        check("R10 masked irq low", int'(irq), 0);
        wr_clear(2'b01);
        check("R8 clear rx", int'(evt), 0);
    endtask

    task automatic t_rx_low;
        rx_clk = 1'b1;
        cyc(6);
        check("R3 long phase ok", int'(evt), 0);
        pulse(0, 1'b0, 1);
        cyc(4);
        check("R3 rx low glitch", int'(evt), 1);
        wr_clear(2'b01);
        rx_clk = 1'b0;
        cyc(6);
        check("R3 return low ok", int'(evt), 0);
    endtask

    task automatic t_tx;
        pulse(1, 1'b1, 1);
        cyc(4);
        check("R5 tx only bit1", int'(evt), 2);
        mask = 2'b10; cyc(1);
        check("R10 irq on", int'(irq), 1);
        mask = 2'b01; cyc(1);
        check("R10 irq other mask", int'(irq), 0);
        wr_clear(2'b01);
        check("R8 zero bit no effect", int'(evt), 2);
        clr_data = 2'b11; cyc(2); clr_data = 2'b00;
        check("R8 no strobe no effect", int'(evt), 2);
        wr_clear(2'b10);
        check("R8 clear tx", int'(evt), 0);
        mask = 2'b00;
    endtask

    task automatic t_quarter;
        for (int i = 0; i < 20; i++) begin
            rx_clk = ~rx_clk;
            cyc(1);
            tx_clk = ~tx_clk;
            cyc(1);
        end
        rx_clk = 1'b0; tx_clk = 1'b0;
        cyc(6);
        check("R4 quarter rate no event", int'(evt), 0);
        pulse(0, 1'b1, 2);
        cyc(4);
        check("R4 two cycle phase ok", int'(evt), 0);
    endtask

    task automatic t_disabled;
        det_en = 1'b0;
        pulse(0, 1'b1, 1);
        cyc(3);
        pulse(1, 1'b1, 1);
        cyc(3);
        pulse(0, 1'b1, 1);
        cyc(5);
        check("R6 disabled no event", int'(evt), 0);
    endtask

    task automatic t_keep;
        det_en = 1'b1;
        cyc(6);
        pulse(0, 1'b1, 1);
        cyc(4);
        check("R7 set before disable", int'(evt), 1);
        det_en = 1'b0;
        cyc(5);
        check("R7 kept after disable", int'(evt), 1);
        det_en = 1'b1;
        wr_clear(2'b01);
        cyc(4);
    endtask

    task automatic t_collide;
        rx_clk = 1'b1;
        cyc(1);
        rx_clk = 1'b0;
        cyc(2);
        clr_we = 1'b1; clr_data = 2'b01;
        cyc(1);
        clr_we = 1'b0; clr_data = 2'b00;
        check("R9 set wins over clear", int'(evt), 1);
        wr_clear(2'b01);
        check("R9 cleared afterwards", int'(evt), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_rx_high();
        t_rx_low();
        t_tx();
        t_quarter();
        t_disabled();
        t_keep();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule